// File: doc/BRIEF.md
# Pulse Edge Timestamper

The block stamps each discriminator pulse of a pixel with two times. A coarse time counter is captured when the pulse starts, and a finer time counter is captured when it ends. When the pulse has ended, both values are presented together with a single-cycle strobe. Both counters run from one fast clock. Each one advances on a clock-enable tick, and its own divider input sets how often that tick comes.

The fast clock runs at twice the reference rate. The trailing counter has a base tick period of 2 fast cycles, which is one reference period. The leading counter has a base period of 4 fast cycles, so it runs at half that base rate. A synchronisation input resets both counters and both tick prescalers, which lets several blocks share a common time origin. The pulse input and the synchronisation input are both asynchronous and both pass through two-flop synchronisers.

Top module: `hit_edge_timestamper`

## Requirements
- R1: After reset, `lead_ts`, `trail_ts` and `pair_valid` are all zero.
- R2: The leading counter is 10 bits wide. It advances once every (1 + `div_lead`) × 4 clock cycles and wraps from 1023 to 0.
- R3: The trailing counter is 7 bits wide. It advances once every (1 + `div_trail`) × 2 clock cycles and wraps from 127 to 0.
- R4: `hit` is sampled by two flops. Suppose `hit` changes between edge n and edge n+1. The counter value captured for that edge is the value the counter holds in the cycle between edge n+2 and edge n+3.
- R5: Suppose `hit` falls between edge n and edge n+1. Then `pair_valid` is high for exactly the one cycle that follows edge n+3. In that same cycle, `lead_ts` shows the count captured at the latest rising edge and `trail_ts` shows the count captured at the falling edge.
- R6: `t0` is sampled by two flops and acts as a synchronous clear of both counters and both prescalers, overriding any tick. Suppose `t0` falls between edge n and edge n+1. The cycle after edge n+2 is then counting cycle 0, and at counting cycle k a counter with tick period P holds floor(k/P).
- R7: The prescaler reloads its divider only when it is cleared or when it produces a tick. A change of `div_lead` or `div_trail` therefore starts with the following period and never shortens the period already running.
- R8: `lead_ts` and `trail_ts` change only in a cycle where `pair_valid` is high. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | Asynchronous discriminator pulse |
| t0 | input | 1 | Asynchronous synchronisation clear |
| div_lead | input | 6 | Divider setting for the leading counter |
| div_trail | input | 6 | Divider setting for the trailing counter |
| lead_ts | output | 10 | Leading-edge time of the last pair |
| trail_ts | output | 7 | Trailing-edge time of the last pair |
| pair_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
A prescaler that drifts by a single cycle, or a counter that loses a wrap, makes a stamped value differ from floor(k/P) once k comes within a cycle of a tick boundary. The table of cases therefore places edges at offsets where a one-cycle error changes the expected count. A divider that is reloaded in the middle of a period corrupts the trailing stamp on the first tick after the change. A wrong synchroniser depth moves the strobe away from edge n+3, and the bench checks the cycles on both sides of that edge.

// File: rtl/hts_pkg.sv
package hts_pkg;
  // Tick period in fast-clock cycles for a divider setting and base period.
  function automatic int unsigned tick_period(int unsigned div, int unsigned base);
    return (div + 1) * base;
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= 1'b0;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_W = 6,
  parameter int BASE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import hts_pkg::*;
  localparam int PER_W = DIV_W + $clog2(BASE) + 1;

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] next_per;
  logic             at_end;

  assign next_per = PER_W'(tick_period(32'(div), BASE));
  assign at_end   = (cnt == per - 1'b1);
  assign tick     = at_end && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      per <= PER_W'(BASE);
    end else if (clr || at_end) begin
      cnt <= '0;
      per <= next_per;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (en)  value <= value + 1'b1;
  end
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture #(
  parameter int LEAD_W  = 10,
  parameter int TRAIL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_s,
  input  logic [LEAD_W-1:0]  lead_cnt,
  input  logic [TRAIL_W-1:0] trail_cnt,
  output logic               rise,
  output logic               fall,
  output logic [LEAD_W-1:0]  lead_ts,
  output logic [TRAIL_W-1:0] trail_ts,
  output logic               pair_valid
);
  logic              hit_d;
  logic [LEAD_W-1:0] lead_hold;

  assign rise = hit_s && !hit_d;
  assign fall = !hit_s && hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_d      <= 1'b0;
      lead_hold  <= '0;
      lead_ts    <= '0;
      trail_ts   <= '0;
      pair_valid <= 1'b0;
    end else begin
      hit_d      <= hit_s;
      pair_valid <= fall;
      if (rise) lead_hold <= lead_cnt;
      if (fall) begin
        lead_ts  <= lead_hold;
        trail_ts <= trail_cnt;
      end
    end
  end
endmodule

// File: rtl/hit_edge_timestamper.sv
module hit_edge_timestamper #(
  parameter int LEAD_W     = 10,
  parameter int TRAIL_W    = 7,
  parameter int DIV_W      = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic               t0,
  input  logic [DIV_W-1:0]   div_lead,
  input  logic [DIV_W-1:0]   div_trail,
  output logic [LEAD_W-1:0]  lead_ts,
  output logic [TRAIL_W-1:0] trail_ts,
  output logic               pair_valid
);
  localparam int TRAIL_BASE = 2;
  localparam int LEAD_BASE  = 2 * TRAIL_BASE;

  logic hit_s, clear;
  logic tick_lead, tick_trail;
  logic rise, fall;
  logic [LEAD_W-1:0]  lead_cnt;
  logic [TRAIL_W-1:0] trail_cnt;

  sync_chain #(.STAGES(SYNC_DEPTH)) u_sync_hit (
    .clk(clk), .rst_n(rst_n), .d_async(hit), .q_sync(hit_s));
  sync_chain #(.STAGES(SYNC_DEPTH)) u_sync_t0 (
    .clk(clk), .rst_n(rst_n), .d_async(t0), .q_sync(clear));

  tick_prescaler #(.DIV_W(DIV_W), .BASE(LEAD_BASE)) u_pre_lead (
    .clk(clk), .rst_n(rst_n), .clr(clear), .div(div_lead), .tick(tick_lead));
  tick_prescaler #(.DIV_W(DIV_W), .BASE(TRAIL_BASE)) u_pre_trail (
    .clk(clk), .rst_n(rst_n), .clr(clear), .div(div_trail), .tick(tick_trail));

  wrap_counter #(.W(LEAD_W)) u_cnt_lead (
    .clk(clk), .rst_n(rst_n), .clr(clear), .en(tick_lead), .value(lead_cnt));
  wrap_counter #(.W(TRAIL_W)) u_cnt_trail (
    .clk(clk), .rst_n(rst_n), .clr(clear), .en(tick_trail), .value(trail_cnt));

  pulse_capture #(.LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .hit_s(hit_s),
    .lead_cnt(lead_cnt), .trail_cnt(trail_cnt),
    .rise(rise), .fall(fall),
    .lead_ts(lead_ts), .trail_ts(trail_ts), .pair_valid(pair_valid));
endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
  parameter int LEAD_W  = 10,
  parameter int TRAIL_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear,
  input logic               tick_lead,
  input logic               tick_trail,
  input logic               fall,
  input logic [LEAD_W-1:0]  lead_cnt,
  input logic [TRAIL_W-1:0] trail_cnt,
  input logic [LEAD_W-1:0]  lead_ts,
  input logic [TRAIL_W-1:0] trail_ts,
  input logic               pair_valid
);
  // R6: a clear leaves both counters at zero on the next cycle
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lead_cnt == '0 && trail_cnt == '0));

  // R3: a trailing tick outside clear advances the count by one, with wrap
  assert_trail_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_trail && !clear) |=> trail_cnt == TRAIL_W'($past(trail_cnt) + 1'b1));

  // R2: a leading tick outside clear advances the count by one, with wrap
  assert_lead_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_lead && !clear) |=> lead_cnt == LEAD_W'($past(lead_cnt) + 1'b1));

  // R2: no leading tick means the count holds
  assert_lead_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_lead && !clear) |=> $stable(lead_cnt));

  // R7: tick periods are never shorter than the base period
  assert_trail_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_trail |=> !tick_trail);

  // R5: a detected falling edge yields a strobe that lasts one cycle
  assert_fall_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pair_valid);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R8: published stamps move only together with the strobe
  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(lead_ts) && $stable(trail_ts)));
endmodule

bind hit_edge_timestamper hts_checker #(.LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .tick_lead(tick_lead), .tick_trail(tick_trail), .fall(fall),
  .lead_cnt(lead_cnt), .trail_cnt(trail_cnt),
  .lead_ts(lead_ts), .trail_ts(trail_ts), .pair_valid(pair_valid));

// File: tb/hit_edge_timestamper_tb.sv
module hit_edge_timestamper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit = 1'b0;
  logic       t0 = 1'b0;
  logic [5:0] div_lead = '0;
  logic [5:0] div_trail = '0;
  logic [9:0] lead_ts;
  logic [6:0] trail_ts;
  logic       pair_valid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hit_edge_timestamper u_dut (
    .clk(clk), .rst_n(rst_n), .hit(hit), .t0(t0),
    .div_lead(div_lead), .div_trail(div_trail),
    .lead_ts(lead_ts), .trail_ts(trail_ts), .pair_valid(pair_valid));

  // columns: div_lead, div_trail, rise offset, pulse width, change offset (0 = none), new div_trail
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{0,  0,  20,  15,  0, 0},
    '{3,  1,  50,  33,  0, 0},
    '{5,  7, 100,  70,  0, 0},
    '{63, 63, 300, 500, 0, 0},
    '{0,  0,  10, 260,  0, 0},
    '{1,  0,  30,  40, 12, 5},
    '{2,  4,  17,  21,  9, 0}
  };

  // Number of ticks in counting cycles 0..k-1. The period restarts from the
  // setting in force at the tick; the setting switches to nd at cycle kc.
  function automatic int ticks(int k, int d, int base, int kc, int nd);
    int n = 0;
    int c_in = 0;
    int per = (d + 1) * base;
    for (int c = 0; c < k; c++) begin
      if (c_in == per - 1) begin
        n++;
        c_in = 0;
        per = ((c >= kc) ? nd + 1 : d + 1) * base;
      end else begin
        c_in++;
      end
    end
    return n;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse t0, then drive one hit pulse; returns the published stamps.
  task automatic run_case(int d1, int d2, int g, int w, int chg, int nd2,
                          bit hold_t0, output int lts, output int tts);
    int f;
    @(negedge clk);
    div_lead = 6'(d1);
    div_trail = 6'(d2);
    t0 = 1'b1;
    repeat (4) @(negedge clk);
    if (!hold_t0) t0 = 1'b0;
    for (int i = 1; i <= g + w; i++) begin
      @(negedge clk);
      if (chg != 0 && i == chg) div_trail = 6'(nd2);
      if (i == g) hit = 1'b1;
      if (i == g + w) hit = 1'b0;
    end
    f = cyc;
    @(negedge clk);
    @(negedge clk);
    check("R5", "strobe early", int'(pair_valid), 0);
    @(negedge clk);
    check("R5", "strobe at edge n+3", int'(pair_valid), 1);
    if (cyc != f + 3) check("R5", "strobe cycle", cyc, f + 3);
    lts = int'(lead_ts);
    tts = int'(trail_ts);
    @(negedge clk);
    check("R5", "strobe one cycle", int'(pair_valid), 0);
    t0 = 1'b0;
  endtask

  initial begin
    int lts, tts;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "lead_ts", int'(lead_ts), 0);
    check("R1", "trail_ts", int'(trail_ts), 0);
    check("R1", "pair_valid", int'(pair_valid), 0);
    rst_n = 1'b1;

    // Table: R2, R3, R4, R6, R7
    for (int v = 0; v < NV; v++) begin
      int d1 = VEC[v][0];
      int d2 = VEC[v][1];
      int g = VEC[v][2];
      int w = VEC[v][3];
      int chg = VEC[v][4];
      int nd2 = VEC[v][5];
      int kc = (chg != 0) ? chg - 2 : 1 << 30;
      run_case(d1, d2, g, w, chg, nd2, 1'b0, lts, tts);
      check("R2", "lead stamp", lts, ticks(g, d1, 4, 1 << 30, d1) % 1024);
      check(chg != 0 ? "R7" : "R3", "trail stamp", tts, ticks(g + w, d2, 2, kc, nd2) % 128);
    end

    // R2: leading counter wrap (1025 ticks of 4 cycles -> 1)
    run_case(0, 0, 4100, 3, 0, 0, 1'b0, lts, tts);
    check("R2", "lead wrap", lts, 1);
    check("R3", "trail wrap", tts, ((4103) / 2) % 128);

    // R6: t0 held high keeps both counters cleared
    run_case(0, 0, 40, 30, 0, 0, 1'b1, lts, tts);
    check("R6", "lead under t0", lts, 0);
    check("R6", "trail under t0", tts, 0);

    // R8: outputs hold between pairs while counters keep running
    run_case(0, 0, 25, 9, 0, 0, 1'b0, lts, tts);
    repeat (50) @(negedge clk);
    check("R8", "lead held", int'(lead_ts), lts);
    check("R8", "trail held", int'(trail_ts), tts);
    check("R8", "no strobe", int'(pair_valid), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule